// File: doc/BRIEF.md
# Banked register file addressing

This block turns the 7-bit register operand of an instruction into a storage location. It holds the data-memory select register and 72 bytes of general storage. Eight of these bytes are common to all banks. The other 64 form four banks of sixteen. Six special registers live outside the block, and the block drives a select line for each of them.

A direct operand in the 0x10–0x1F window is steered into the bank named by the upper select bits. An operand of 0x00 makes the access indirect: the select register's low seven bits become the absolute target address, with no bank steering.

Reads are combinational within the cycle. Writes take effect at the rising clock edge. The power-on reset is asynchronous and active low. Two synchronous reset requests model the external-clear and watchdog cases. During a reset-request cycle every write is dropped.

Top module: `bank_regfile`

## Requirements
- R1: A direct operand in 0x08–0x0F reads and writes one of eight common bytes, whatever the select register holds.
- R2: A direct operand in 0x10–0x1F reaches byte (operand − 0x10) of the bank given by select bits 6:5 (00, 01, 10, 11 give the windows at 0x10, 0x30, 0x50, 0x70), and the four banks are separate storage.
- R3: A direct operand in 0x30–0x3F, 0x50–0x5F or 0x70–0x7F reaches that absolute bank byte, regardless of the select bits.
- R4: Operand 0x00 accesses the absolute address held in select bits 6:0, with no bank steering; a pointer of 0x04 reaches the select register itself.
- R5: Operand 0x00 with a pointer of 0x00 reads 0x00, and a write to it changes nothing.
- R6: Reading the select register (address 0x04) returns bit 7 as 1, with bits 6:0 equal to the last value written.
- R7: After the asynchronous power-on reset, the select register reads 0x80.
- R8: An external-clear cycle forces select bits 6:5 to 00 and keeps bits 4:0.
- R9: A watchdog-clear cycle leaves the select register unchanged. During any external- or watchdog-clear cycle, all writes are dropped.
- R10: `spc_sel` bits 0..5 select the registers at addresses 0x01, 0x02, 0x03, 0x05, 0x06 and 0x07. A bit is high while a read or write strobe targets that address, directly or indirectly. At most one bit is high, and `rdata` is 0x00 for these addresses.
- R11: Addresses 0x20–0x2F, 0x40–0x4F and 0x60–0x6F read 0x00 and ignore writes.
- R12: `rdata` is 0x00 whenever `rd_en` is low.
- R13: A read in the same cycle as a write to the same byte returns the old value. The new value is seen from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_clr | input | 1 | External-clear request, synchronous |
| wdg_clr | input | 1 | Watchdog-clear request, synchronous |
| addr | input | 7 | Register operand |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| spc_sel | output | 6 | One-hot select of external special registers |

## Verification
On every cycle the assertions check several rules:
- the special selects are never more than one-hot;
- read data is zero without a read strobe;
- bit 7 reads as one;
- a null-pointer write never reaches storage;
- the select register holds through a watchdog cycle;
- an external clear empties the bank bits and keeps the low five bits.

Some behaviour only the bench's scenarios can show. These are that each bank is separate storage, that the steered window and the absolute aliases reach the same bytes, that indirect accesses land at the right place, and that the unimplemented gaps stay empty. The bench shows this by writing distinct patterns and reading them back through other paths.

// File: rtl/bfa_pkg.sv
package bfa_pkg;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int COMMON_N   = 8;
  localparam int BANK_N     = 4;
  localparam int BANK_DEPTH = 16;
  localparam int STORE_N    = COMMON_N + BANK_N * BANK_DEPTH;
  localparam int IDX_W      = $clog2(STORE_N);
  localparam int OFS_W      = $clog2(BANK_DEPTH);
  localparam int COMMON_IW  = $clog2(COMMON_N);
  localparam int BSEL_LSB   = OFS_W + 1;
  localparam int SPC_N      = 6;
  localparam int MSR_ADDR   = 4;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_STORE = 2'd1,
    TGT_MSR   = 2'd2,
    TGT_SPC   = 2'd3
  } tgt_kind_e;

  typedef struct packed {
    tgt_kind_e          kind;
    logic [IDX_W-1:0]   idx;
    logic [SPC_N-1:0]   spc;
  } tgt_t;
endpackage

// File: rtl/bfa_decode.sv
module bfa_decode
  import bfa_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] ptr,
  output tgt_t              tgt
);
  logic [ADDR_W-1:0] eff;

  // effective address: indirect, steered window, or absolute
  always_comb begin
    if (addr == '0) begin
      eff = ptr;
    end else if (addr[ADDR_W-1:OFS_W] == 3'b001) begin
      eff = {ptr[ADDR_W-1:BSEL_LSB], addr[OFS_W:0]};
    end else begin
      eff = addr;
    end
  end

  // classify the effective address
  always_comb begin
    tgt.kind = TGT_NONE;
    tgt.idx  = '0;
    tgt.spc  = '0;
    if (eff == '0) begin
      tgt.kind = TGT_NONE;
    end else if (eff == ADDR_W'(MSR_ADDR)) begin
      tgt.kind = TGT_MSR;
    end else if (eff < ADDR_W'(COMMON_N)) begin
      tgt.kind = TGT_SPC;
      for (int k = 1; k < COMMON_N; k++) begin
        if (k != MSR_ADDR && eff == ADDR_W'(k)) begin
          tgt.spc[(k < MSR_ADDR) ? k - 1 : k - 2] = 1'b1;
        end
      end
    end else if (eff < ADDR_W'(2 * COMMON_N)) begin
      tgt.kind = TGT_STORE;
      tgt.idx  = IDX_W'(eff[COMMON_IW-1:0]);
    end else if (eff[OFS_W]) begin
      tgt.kind = TGT_STORE;
      tgt.idx  = IDX_W'(COMMON_N) +
                 IDX_W'({eff[ADDR_W-1:BSEL_LSB], eff[OFS_W-1:0]});
    end
  end
endmodule

// File: rtl/bfa_msr.sv
module bfa_msr
  import bfa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clr,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] q
);
  logic [ADDR_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (ext_clr) begin
      nxt = {{(ADDR_W-BSEL_LSB){1'b0}}, q[BSEL_LSB-1:0]};
    end else if (we) begin
      nxt = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // R8
  ext_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clr |=> (q[ADDR_W-1:BSEL_LSB] == '0) &&
                (q[BSEL_LSB-1:0] == $past(q[BSEL_LSB-1:0])));
endmodule

// File: rtl/bfa_store.sv
module bfa_store
  import bfa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [STORE_N];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  always_comb begin
    if (idx < IDX_W'(STORE_N)) rdata = mem[idx];
    else                       rdata = '0;
  end

  // R11
  store_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (idx < IDX_W'(STORE_N)));
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bfa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clr,
  input  logic              wdg_clr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [SPC_N-1:0]  spc_sel
);
  tgt_t              tgt;
  logic [ADDR_W-1:0] msr_q;
  logic [DATA_W-1:0] st_rd;
  logic              wr_ok;
  logic              st_we;
  logic              msr_we;

  bfa_decode u_dec (
    .addr (addr),
    .ptr  (msr_q),
    .tgt  (tgt)
  );

  assign wr_ok  = wr_en && !ext_clr && !wdg_clr;
  assign st_we  = wr_ok && (tgt.kind == TGT_STORE);
  assign msr_we = wr_ok && (tgt.kind == TGT_MSR);

  bfa_msr u_msr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_clr (ext_clr),
    .we      (msr_we),
    .wdata   (wdata[ADDR_W-1:0]),
    .q       (msr_q)
  );

  bfa_store u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (st_we),
    .idx   (tgt.idx),
    .wdata (wdata),
    .rdata (st_rd)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (tgt.kind)
        TGT_STORE: rdata = st_rd;
        TGT_MSR:   rdata = {1'b1, msr_q};
        default:   rdata = '0;
      endcase
    end
  end

  assign spc_sel = (rd_en || wr_en) ? tgt.spc : '0;

  // R10
  spc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(spc_sel));
  // R12
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));
  // R6
  msr_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(MSR_ADDR)) |-> rdata[DATA_W-1]);
  // R5
  null_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0 && msr_q == '0) |-> (!st_we && !msr_we));
  // R9
  wdg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdg_clr && !ext_clr) |=> $stable(msr_q));
endmodule

// File: tb/bank_regfile_bench.sv
module bank_regfile_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clr = 1'b0, wdg_clr = 1'b0;
  logic [6:0] addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [5:0] spc_sel;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_msr = 0;
  int m_mem [128];
  bit m_val [128];

  always #4 clk = ~clk;

  bank_regfile u_bank_regfile (
    .clk(clk), .rst_n(rst_n), .ext_clr(ext_clr), .wdg_clr(wdg_clr),
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .spc_sel(spc_sel)
  );

  function automatic int eff_of(int a);
    if (a == 0) return m_msr;
    if (a >= 16 && a < 32) return a + 32 * ((m_msr >> 5) & 3);
    return a;
  endfunction

  function automatic bit is_mem(int e);
    return (e >= 8 && e < 16) || (e >= 16 && (e % 32) >= 16);
  endfunction

  function automatic int spc_of(int e);
    case (e)
      1: return 1;  2: return 2;  3: return 4;
      5: return 8;  6: return 16; 7: return 32;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int a, bit rd, bit wr, int d, bit ex, bit wd, string tag);
    int e, exp_rd, exp_sp;
    bit known;
    @(negedge clk);
    addr = 7'(a); rd_en = rd; wr_en = wr; wdata = 8'(d);
    ext_clr = ex; wdg_clr = wd;
    #2;
    e = eff_of(a);
    known = 1;
    exp_rd = 0;
    if (rd) begin
      if (e == 4) exp_rd = 128 + m_msr;
      else if (is_mem(e)) begin
        known = m_val[e];
        exp_rd = m_mem[e];
      end
    end
    if (known) check({tag, " rdata"}, int'(rdata), exp_rd);
    exp_sp = (rd || wr) ? spc_of(e) : 0;
    check({tag, " spc_sel"}, int'(spc_sel), exp_sp);
    if (wr && !ex && !wd) begin
      if (e == 4) m_msr = d & 127;
      else if (is_mem(e)) begin
        m_mem[e] = d & 255;
        m_val[e] = 1;
      end
    end
    if (ex) m_msr = m_msr & 31;
  endtask

  task automatic wr(int a, int d, string tag);
    cyc(a, 0, 1, d, 0, 0, tag);
  endtask

  task automatic rd(int a, string tag);
    cyc(a, 1, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 power-on value
    rd(4, "R7");
    // R1 common bytes under two bank settings
    for (int i = 8; i < 16; i++) wr(i, i * 17, "R1");
    wr(4, 8'h60, "R6");
    for (int i = 8; i < 16; i++) rd(i, "R1");
    // R2 fill each bank through the steered window
    for (int b = 0; b < 4; b++) begin
      wr(4, b << 5, "R2");
      for (int i = 16; i < 32; i++) wr(i, (b * 16 + i) ^ 8'hA5, "R2");
    end
    for (int b = 3; b >= 0; b--) begin
      wr(4, (b << 5) | 5'h0B, "R2");
      for (int i = 16; i < 32; i++) rd(i, "R2");
    end
    // R3 absolute aliases regardless of bank bits
    wr(4, 0, "R3");
    for (int i = 48; i < 128; i += 7) rd(i, "R3");
    wr(8'h55, 8'h3C, "R3");
    wr(4, 8'h40, "R3");
    rd(8'h15, "R3");
    // R6 bit 7 forced, low bits writable
    wr(4, 8'h7F, "R6");
    rd(4, "R6");
    wr(4, 8'h00, "R6");
    rd(4, "R6");
    // R4 indirect targets
    wr(4, 8'h35, "R4");
    wr(0, 8'hC3, "R4");
    rd(0, "R4");
    rd(8'h35, "R4");
    wr(4, 8'h1A, "R4");
    rd(0, "R4");
    wr(4, 8'h0A, "R4");
    wr(0, 8'h99, "R4");
    rd(8'h0A, "R4");
    wr(4, 8'h04, "R4");
    rd(0, "R4");
    wr(0, 8'h72, "R4");
    rd(4, "R4");
    // R5 null pointer
    wr(4, 0, "R5");
    rd(0, "R5");
    wr(0, 8'hFF, "R5");
    rd(4, "R5");
    for (int i = 8; i < 16; i++) rd(i, "R5");
    rd(16, "R5");
    // R10 special selects, direct and indirect
    for (int i = 1; i < 8; i++) rd(i, "R10");
    for (int i = 1; i < 8; i++) wr(i, 8'h11, "R10");
    wr(4, 8'h06, "R10");
    rd(0, "R10");
    wr(0, 8'h5A, "R10");
    wr(4, 8'h02, "R10");
    cyc(0, 0, 0, 0, 0, 0, "R10");
    // R11 unimplemented gaps
    wr(8'h20, 8'hAA, "R11");
    wr(8'h45, 8'hAB, "R11");
    wr(8'h6F, 8'hAC, "R11");
    rd(8'h20, "R11");
    rd(8'h45, "R11");
    rd(8'h6F, "R11");
    wr(4, 8'h2F, "R11");
    rd(0, "R11");
    // R8 external clear, also with a concurrent write
    wr(4, 8'h7F, "R8");
    cyc(9, 0, 1, 8'h01, 1, 0, "R8");
    rd(4, "R8");
    rd(9, "R8");
    wr(4, 8'h52, "R8");
    cyc(4, 1, 1, 8'h33, 1, 0, "R8");
    rd(4, "R8");
    // R9 watchdog clear drops writes, keeps select
    wr(4, 8'h6E, "R9");
    cyc(4, 1, 1, 8'h01, 0, 1, "R9");
    rd(4, "R9");
    cyc(12, 1, 1, 8'hEE, 0, 1, "R9");
    rd(12, "R9");
    // R12 no read strobe
    cyc(4, 0, 0, 0, 0, 0, "R12");
    cyc(8, 0, 1, 8'h44, 0, 0, "R12");
    // R13 same-cycle read returns old value
    cyc(8, 1, 1, 8'h87, 0, 0, "R13");
    rd(8, "R13");
    // R7 second power-on
    @(negedge clk);
    rst_n = 1'b0;
    m_msr = 0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(4, "R7");
    rd(15, "R7");
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule